// File: doc/BRIEF.md
# Command Packet Stream Parser

This block sits on a stream of 32-bit command words that arrives over a valid/ready handshake. It reads each header word and classifies it by the packet type in its top nibble. It pulls out the payload length and either a register index or an opcode, and it verifies the parity bits that the newer header formats carry. The payload words that follow pass straight through to a downstream consumer. Each is tagged with its register address or opcode, flagged as a register write or an opcode argument, and marked as the first and/or last word of its packet. Register-write payloads advance the address by one per word. Opcode payloads keep the opcode as their tag.

Control is a two-state machine. `ST_HEAD` waits for a header word and always accepts it. It moves to `ST_BODY` through the transition `HEAD_TO_BODY` when the header is legal and announces at least one payload word. A legal header with no payload, or an illegal header, leaves the parser in `ST_HEAD` (transition `HEAD_STAY`). `ST_BODY` forwards words while downstream is ready (transition `BODY_STAY`). It returns to `ST_HEAD` through `BODY_TO_HEAD` when the word marked last is handed over. An illegal header sets a sticky error flag and is discarded, and the next word is taken as a fresh header.

Top module: `cmdp_parser`

## Requirements
- R1: The packet type is decoded from header bits [31:28]: 0x0 legacy register write, 0x8 no-op, 0xC legacy opcode, 0x4 register write with parity, 0x7 opcode with parity. Any other value sets `err_flag`, the header is dropped, and the next word is treated as a header.
- R2: The parity of a value is odd parity: the bit is 1 when the value has an even number of ones, so zero gives 1. A 0x4 header checks bit 7 against the parity of bits [6:0] and bit 27 against the parity of bits [25:8]. A 0x7 header checks bit 15 against the parity of bits [14:0] and bit 23 against the parity of bits [22:16]. Any mismatch sets `err_flag` and drops the header with no payload forwarded.
- R3: A 0x4 header forwards bits [6:0] payload words with `out_is_reg`=1. The first word's `out_tag` is the 18-bit index in bits [25:8], and each later word's tag is one above the previous word's, modulo 2^18.
- R4: A 0x7 header forwards bits [14:0] payload words with `out_is_reg`=0, each with `out_tag` equal to the 7-bit opcode in bits [22:16].
- R5: A 0x0 header forwards (bits [27:16] + 1) words as register writes starting at the index in bits [14:0], incrementing per word. A 0xC header forwards (bits [27:16] + 1) words tagged with the opcode in bits [15:8]. Neither is parity checked.
- R6: A 0x8 header, and a 0x4 or 0x7 header with a zero count, complete at once. No payload word is output, and the next word is a header.
- R7: `out_first` is 1 exactly on the first payload word of a packet. `out_last` is 1 exactly on its final word.
- R8: While a payload word is offered, `out_data` equals `in_word` and `in_ready` follows `out_ready`. A stalled word is neither lost nor repeated, and its tag and markers hold.
- R9: After reset the parser waits for a header with `in_ready`=1, `out_valid`=0 and `err_flag`=0. Once set, `err_flag` stays set until reset.
- R10: Header words are never presented on the output. `out_valid` is 1 only while a payload word is being offered on `in_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Parser takes the offered word this cycle |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Payload word offered downstream |
| out_ready | input | 1 | Downstream takes the payload word |
| out_data | output | 32 | Payload word |
| out_tag | output | 18 | Register address or opcode of this word |
| out_is_reg | output | 1 | 1 for a register write, 0 for an opcode argument |
| out_first | output | 1 | First payload word of the packet |
| out_last | output | 1 | Final payload word of the packet |
| err_flag | output | 1 | Sticky illegal-header flag |

## Verification
The properties assume the upstream side keeps `in_valid` and `in_word` steady while a word is offered but not taken. They also assume the stream is split into packets only by the header lengths, so a payload word is never mistaken for a header except after the designed resynchronisation. The stimulus holds each word on the input until the cycle it is accepted and builds every header from its fields with computed parity bits. It corrupts parity or type only in the error cases, where it then relies on resynchronisation to continue.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam int CMD_W = 32;
    localparam int CNT_W = 15;
    localparam int TAG_W = 18;

    // nibble index -> odd parity bit (1 when the nibble has even weight)
    localparam logic [15:0] PAR_LUT = 16'h9669;

    typedef enum logic [0:0] {
        ST_HEAD = 1'b0,
        ST_BODY = 1'b1
    } parse_state_e;

    function automatic logic odd_par(input logic [CMD_W-1:0] v);
        logic [3:0] fold;
        fold = '0;
        for (int i = 0; i < CMD_W / 4; i++) begin
            fold = fold ^ v[i*4 +: 4];
        end
        return PAR_LUT[fold];
    endfunction

endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
    import cmdp_pkg::*;
#(
    parameter int W_CMD = CMD_W,
    parameter int W_CNT = CNT_W,
    parameter int W_TAG = TAG_W
) (
    input  logic [W_CMD-1:0] word,
    output logic             hdr_ok,
    output logic             has_payload,
    output logic [W_CNT-1:0] count,
    output logic [W_TAG-1:0] tag,
    output logic             is_reg
);
    localparam logic [3:0] TY_LREG = 4'h0;
    localparam logic [3:0] TY_NOP  = 4'h8;
    localparam logic [3:0] TY_LOPC = 4'hC;
    localparam logic [3:0] TY_PREG = 4'h4;
    localparam logic [3:0] TY_POPC = 4'h7;

    logic [W_CNT-1:0] legacy_cnt;
    assign legacy_cnt = W_CNT'(word[27:16]) + W_CNT'(1);

    always_comb begin
        hdr_ok = 1'b0;
        count  = '0;
        tag    = '0;
        is_reg = 1'b0;
        case (word[31:28])
            TY_LREG: begin
                hdr_ok = 1'b1;
                count  = legacy_cnt;
                tag    = W_TAG'(word[14:0]);
                is_reg = 1'b1;
            end
            TY_NOP: begin
                hdr_ok = 1'b1;
            end
            TY_LOPC: begin
                hdr_ok = 1'b1;
                count  = legacy_cnt;
                tag    = W_TAG'(word[15:8]);
            end
            TY_PREG: begin
                hdr_ok = (odd_par(CMD_W'(word[6:0])) == word[7]) &&
                         (odd_par(CMD_W'(word[25:8])) == word[27]);
                count  = W_CNT'(word[6:0]);
                tag    = W_TAG'(word[25:8]);
                is_reg = 1'b1;
            end
            TY_POPC: begin
                hdr_ok = (odd_par(CMD_W'(word[14:0])) == word[15]) &&
                         (odd_par(CMD_W'(word[22:16])) == word[23]);
                count  = W_CNT'(word[14:0]);
                tag    = W_TAG'(word[22:16]);
            end
            default: hdr_ok = 1'b0;
        endcase
    end

    assign has_payload = hdr_ok && (count != '0);

endmodule

// File: rtl/cmdp_beat_track.sv
module cmdp_beat_track
    import cmdp_pkg::*;
#(
    parameter int W_CNT = CNT_W,
    parameter int W_TAG = TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W_CNT-1:0] ld_count,
    input  logic [W_TAG-1:0] ld_tag,
    input  logic             ld_is_reg,
    input  logic             step,
    output logic [W_TAG-1:0] tag,
    output logic             is_reg,
    output logic             first,
    output logic             last
);
    logic [W_CNT-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            tag    <= '0;
            is_reg <= 1'b0;
            first  <= 1'b0;
        end else if (load) begin
            remain <= ld_count;
            tag    <= ld_tag;
            is_reg <= ld_is_reg;
            first  <= 1'b1;
        end else if (step) begin
            remain <= remain - W_CNT'(1);
            first  <= 1'b0;
            if (is_reg) begin
                tag <= tag + W_TAG'(1);
            end
        end
    end

    assign last = (remain == W_CNT'(1));

endmodule

// File: rtl/cmdp_parser.sv
module cmdp_parser
    import cmdp_pkg::*;
#(
    parameter int W_CMD = CMD_W,
    parameter int W_CNT = CNT_W,
    parameter int W_TAG = TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [W_CMD-1:0] in_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [W_CMD-1:0] out_data,
    output logic [W_TAG-1:0] out_tag,
    output logic             out_is_reg,
    output logic             out_first,
    output logic             out_last,
    output logic             err_flag
);
    parse_state_e     state, state_nx;
    logic             d_ok, d_pay, d_is_reg;
    logic [W_CNT-1:0] d_cnt;
    logic [W_TAG-1:0] d_tag;
    logic             trk_load, trk_step, err_set;

    cmdp_hdr_decode #(.W_CMD(W_CMD), .W_CNT(W_CNT), .W_TAG(W_TAG)) u_dec (
        .word        (in_word),
        .hdr_ok      (d_ok),
        .has_payload (d_pay),
        .count       (d_cnt),
        .tag         (d_tag),
        .is_reg      (d_is_reg)
    );

    cmdp_beat_track #(.W_CNT(W_CNT), .W_TAG(W_TAG)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .ld_count  (d_cnt),
        .ld_tag    (d_tag),
        .ld_is_reg (d_is_reg),
        .step      (trk_step),
        .tag       (out_tag),
        .is_reg    (out_is_reg),
        .first     (out_first),
        .last      (out_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HEAD;
        end else begin
            state <= state_nx;
        end
    end

    // sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (err_set) begin
            err_flag <= 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        trk_load  = 1'b0;
        trk_step  = 1'b0;
        err_set   = 1'b0;
        unique case (state)
            ST_HEAD: begin
                in_ready = 1'b1;
                trk_load = in_valid && d_pay;
                err_set  = in_valid && !d_ok;
                if (trk_load) begin
                    state_nx = ST_BODY;
                end
            end
            ST_BODY: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                trk_step  = in_valid && out_ready;
                if (trk_step && out_last) begin
                    state_nx = ST_HEAD;
                end
            end
        endcase
    end

    assign out_data = in_word;

endmodule

// File: rtl/cmdp_parser_chk.sv
module cmdp_parser_chk #(
    parameter int W_CMD = 32,
    parameter int W_TAG = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [W_CMD-1:0] in_word,
    input logic             out_valid,
    input logic             out_ready,
    input logic [W_CMD-1:0] out_data,
    input logic [W_TAG-1:0] out_tag,
    input logic             out_is_reg,
    input logic             out_first,
    input logic             out_last,
    input logic             err_flag
);
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R9

    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid); // R10

    AST_BODY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == out_ready) && (out_data == in_word)); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            $stable(out_tag) && $stable(out_first) && $stable(out_last)); // R8

    AST_REG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_is_reg && !out_last) |=>
            out_tag == $past(out_tag) + W_TAG'(1)); // R3

    AST_OPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_is_reg && !out_last) |=>
            $stable(out_tag)); // R4

    AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> !out_first); // R7

endmodule

bind cmdp_parser cmdp_parser_chk #(.W_CMD(W_CMD), .W_TAG(W_TAG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_tag    (out_tag),
    .out_is_reg (out_is_reg),
    .out_first  (out_first),
    .out_last   (out_last),
    .err_flag   (err_flag)
);

// File: tb/test_cmdp_parser.sv
module test_cmdp_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [17:0] out_tag;
    logic        out_is_reg;
    logic        out_first;
    logic        out_last;
    logic        err_flag;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    bp_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    string cur_req = "R9";

    // behavioural reference state
    int rem = 0;
    int mtag = 0;
    bit misreg = 1'b0;
    bit mfirst = 1'b0;
    bit merr = 1'b0;

    always #2 clk = ~clk;

    cmdp_parser i_cmdp_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_tag    (out_tag),
        .out_is_reg (out_is_reg),
        .out_first  (out_first),
        .out_last   (out_last),
        .err_flag   (err_flag)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit bpar(input int v);
        return ($countones(v) % 2) == 0;
    endfunction

    function automatic logic [31:0] mk4(input int rg, input int cnt);
        return {4'h4, bpar(rg), 1'b0, rg[17:0], bpar(cnt), cnt[6:0]};
    endfunction

    function automatic logic [31:0] mk7(input int op, input int cnt);
        return {4'h7, 4'h0, bpar(op), op[6:0], bpar(cnt), cnt[14:0]};
    endfunction

    function automatic logic [31:0] mk0(input int rg, input int cnt);
        return {4'h0, 12'(cnt - 1), 1'b0, rg[14:0]};
    endfunction

    function automatic logic [31:0] mk3(input int op, input int cnt);
        return {4'hC, 12'(cnt - 1), op[7:0], 8'h00};
    endfunction

    // back-pressure pattern
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = bp_en ? (lfsr[0] | lfsr[1]) : 1'b1;
    end

    // per-cycle comparison against the reference, then reference update
    always begin
        @(negedge clk);
        #1;
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
        if (!rst_n) begin
            rem = 0; mtag = 0; misreg = 0; mfirst = 0; merr = 0;
        end else begin
            bit exp_ov;
            bit exp_ir;
            exp_ov = in_valid && (rem > 0);
            exp_ir = (rem > 0) ? out_ready : 1'b1;
            chk(out_valid, exp_ov, (rem > 0) ? "R8" : "R10", "out_valid");
            chk(in_ready, exp_ir, (rem > 0) ? "R8" : cur_req, "in_ready");
            chk(err_flag, merr, merr ? "R9" : cur_req, "err_flag");
            if (exp_ov) begin
                chk(out_data, in_word, "R8", "out_data");
                chk(out_tag, mtag, misreg ? "R3" : "R4", "out_tag");
                chk(out_is_reg, misreg, cur_req, "out_is_reg");
                chk(out_first, mfirst, "R7", "out_first");
                chk(out_last, rem == 1, "R7", "out_last");
            end
            if (in_valid && exp_ir) begin
                if (rem > 0) begin
                    rem--;
                    mfirst = 0;
                    if (misreg) mtag = (mtag + 1) % (1 << 18);
                end else begin
                    logic [31:0] w;
                    w = in_word;
                    mfirst = 1;
                    case (w[31:28])
                        4'h0: begin rem = int'(w[27:16]) + 1; mtag = int'(w[14:0]); misreg = 1; end
                        4'h8: begin end
                        4'hC: begin rem = int'(w[27:16]) + 1; mtag = int'(w[15:8]); misreg = 0; end
                        4'h4: begin
                            if (bpar(int'(w[6:0])) != w[7] || bpar(int'(w[25:8])) != w[27]) merr = 1;
                            else begin rem = int'(w[6:0]); mtag = int'(w[25:8]); misreg = 1; end
                        end
                        4'h7: begin
                            if (bpar(int'(w[14:0])) != w[15] || bpar(int'(w[22:16])) != w[23]) merr = 1;
                            else begin rem = int'(w[14:0]); mtag = int'(w[22:16]); misreg = 0; end
                        end
                        default: merr = 1;
                    endcase
                end
            end
        end
    end

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic put(input logic [31:0] w);
        bit acc;
        in_valid = 1'b1;
        in_word  = w;
        do begin
            #1;
            acc = in_ready;
            @(negedge clk);
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic payload(input int n, input int seed);
        for (int i = 0; i < n; i++) put(32'(seed * 32'h9E3779B1 + i * 32'h01000193));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        idle(2);
        #1;
        chk(in_ready, 1, "R9", "reset in_ready");
        chk(out_valid, 0, "R9", "reset out_valid");
        chk(err_flag, 0, "R9", "reset err_flag");
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        cur_req = "R3";
        put(mk4(18'h01234, 3)); payload(3, 1);
        put(mk4(18'h3FFFE, 4)); payload(4, 2);   // address wraps
        cur_req = "R4";
        put(mk7(7'h26, 2)); payload(2, 3);
        cur_req = "R5";
        put(mk0(15'h7FFE, 2)); payload(2, 4);
        put(mk3(8'hA5, 1)); payload(1, 5);
        cur_req = "R6";
        put(32'h8000_0000);
        put(mk4(18'h00100, 0));
        put(mk7(7'h10, 0));
        put(32'h8000_0000);
        cur_req = "R7";
        put(mk4(18'h00200, 1)); payload(1, 6);

        bp_en = 1'b1;
        cur_req = "R8";
        put(mk4(18'h00A00, 127)); payload(127, 7);
        put(mk7(7'h7F, 5)); payload(5, 8);
        put(mk3(8'h01, 6)); payload(6, 9);
        bp_en = 1'b0;
        idle(2);
        #1 chk(err_flag, 0, "R2", "no error on good parity");
        @(negedge clk);

        cur_req = "R2";
        put(mk4(18'h00300, 2) ^ 32'h0000_0080);  // count parity flipped
        idle(1);
        #1 chk(err_flag, 1, "R2", "count parity error");
        @(negedge clk);
        cur_req = "R1";
        put(mk7(7'h05, 1)); payload(1, 10);      // resync on next word
        cur_req = "R9";
        put(mk4(18'h00010, 2)); payload(2, 11);
        idle(1);
        #1 chk(err_flag, 1, "R9", "error sticky");
        @(negedge clk);

        do_reset();
        cur_req = "R2";
        put(mk7(7'h11, 1) ^ 32'h0080_0000);      // opcode parity flipped
        cur_req = "R2";
        put(mk4(18'h00040, 1) ^ 32'h0800_0000);  // index parity flipped
        idle(1);
        #1 chk(err_flag, 1, "R2", "index/opcode parity error");
        @(negedge clk);

        do_reset();
        cur_req = "R1";
        put(32'h3000_0002);                      // unknown type
        put(mk4(18'h00050, 1)); payload(1, 12);
        idle(1);
        #1 chk(err_flag, 1, "R1", "unknown type error");
        @(negedge clk);

        idle(3);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule